// File: doc/BRIEF.md
# Flash Word Program Sequencer

This block sits on the host side of an asynchronous NOR flash bus and writes a run of consecutive words into the array. Software or an upstream engine provides a first address, a word count and a stream of data words. Each word becomes its own bus transaction. The block writes the three-cycle unlock and setup sequence, then writes the word to its target address. It then reads status back until the device reports that the word has landed. After that it steps to the next address. When the whole run has verified, it raises a one-cycle completion pulse.

Completion is detected with data polling on bit 7. While the device is busy, it returns the complement of the programmed bit 7. Once it has finished, it returns the array data, so bit 7 then matches. Bit 5 of the status word reports that the device has exceeded its internal time limit. When that bit is seen, the block allows one more read. If that read still does not match, the block raises a sticky error and stops driving the bus until the next start.

Strobe widths are set in clock cycles by parameters. The bus outputs are all registered. The block never drives the write and output enables low at the same time.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `bus_we_n` and `bus_oe_n` are high, and `done`, `error` and `dat_ready` are low.
- R2: Every word is written as four bus writes, in this order: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, and then the data word to its target address. Command writes zero-extend the 8-bit code and the 12-bit address.
- R3: Each bus write holds `bus_we_n` low for exactly WE_CYC cycles, with `bus_addr` and `bus_wdata` stable throughout. Consecutive writes are separated by at least one high cycle.
- R4: After the data write, the block reads status with `bus_oe_n` low for RD_CYC cycles per read. It repeats reads until bit 7 of the value sampled in the last low cycle equals bit 7 of the programmed word. `bus_we_n` and `bus_oe_n` are never low together.
- R5: A word is taken from the stream on a rising edge where `dat_valid` and `dat_ready` are both high. `dat_ready` is high only while the block waits for the next word. The target address starts at `start_addr` and increases by one per word.
- R6: `done` is high for exactly one cycle. For N words, where word k needs P_k status reads, `done` rises the sum over k of (4·(WE_CYC+1) + P_k·(RD_CYC+1) + 1) edges after the edge that samples `start`, provided the data stream is always valid.
- R7: A non-matching read with bit 5 high arms one more read. If that next read also fails to match, `error` rises one edge after it. The block then stops: no strobes and `dat_ready` low. `error` stays high until the next `start`, which clears it.
- R8: A non-matching read with bit 5 low always leads to another read and never to an error, however many reads are needed.
- R9: A `start` with `word_count` equal to zero produces `done` on the same edge that samples `start`, with no bus activity.
- R10: `start` is ignored while a run is in progress. The address, the count and the timing of the run are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled when idle or halted) |
| start_addr | input | AW | First target word address |
| word_count | input | CW | Number of words in the run |
| dat_in | input | DW | Data stream word |
| dat_valid | input | 1 | Stream word valid |
| dat_ready | output | 1 | Block accepts a stream word |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | DW | Flash bus write data |
| bus_rdata | input | DW | Flash bus read data |
| bus_we_n | output | 1 | Write enable strobe, active low |
| bus_oe_n | output | 1 | Output enable strobe, active low |
| done | output | 1 | One-cycle pulse when the last word has verified |
| error | output | 1 | Sticky time-limit failure flag |

## Verification
A word is accepted one edge after the block enters its fetch state. Each of the four writes then takes WE_CYC+1 edges, and each status read takes RD_CYC+1 edges. `done` follows one edge after the matching read, and `error` one edge after the second failing read. The bench counts negedges from the edge that samples `start` and compares the arrival edge of `done` or `error` with a total computed from the busy length it programmed into its flash model. The model logs each write and counts strobe widths at the falling clock edge, when the registered bus outputs are settled. Write order, strobe width and read count are therefore checked after the run, against the same formula.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WRITE,
    S_POLL,
    S_HALT
  } seq_state_t;

  localparam logic [11:0] UNLK_A0 = 12'h555;
  localparam logic [11:0] UNLK_A1 = 12'h2AA;
  localparam logic [7:0]  UNLK_D0 = 8'hAA;
  localparam logic [7:0]  UNLK_D1 = 8'h55;
  localparam logic [7:0]  PGM_CMD = 8'hA0;

  localparam int POLL_BIT = 7;
  localparam int TMO_BIT  = 5;

endpackage

// File: rtl/flash_strobe_gen.sv
`timescale 1ns/1ps
module flash_strobe_gen #(
  parameter int DW     = 16,
  parameter int WE_CYC = 3,
  parameter int RD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic [DW-1:0] rd_in,
  output logic          we_n,
  output logic          oe_n,
  output logic          cyc_done,
  output logic [DW-1:0] rd_q
);
  localparam int CMAX  = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int CNT_W = (CMAX > 1) ? $clog2(CMAX) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      cyc_done <= 1'b0;
      cnt      <= '0;
      rd_q     <= '0;
    end else begin
      cyc_done <= 1'b0;
      if (!we_n) begin
        if (cnt == '0) begin
          we_n     <= 1'b1;
          cyc_done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (!oe_n) begin
        if (cnt == '0) begin
          oe_n     <= 1'b1;
          cyc_done <= 1'b1;
          rd_q     <= rd_in;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (wr_go) begin
        we_n <= 1'b0;
        cnt  <= CNT_W'(WE_CYC - 1);
      end else if (rd_go) begin
        oe_n <= 1'b0;
        cnt  <= CNT_W'(RD_CYC - 1);
      end
    end
  end

  // R4
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));

endmodule

// File: rtl/flash_poll_eval.sv
`timescale 1ns/1ps
module flash_poll_eval
  import flash_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rd_word,
  input  logic          tgt_bit,
  input  logic          armed,
  output logic          match,
  output logic          retry,
  output logic          fault
);
  localparam logic [DW-1:0] USED = (DW'(1) << POLL_BIT) | (DW'(1) << TMO_BIT);

  logic unused_bits;
  assign unused_bits = ^(rd_word & ~USED);

  always_comb begin
    match = (rd_word[POLL_BIT] == tgt_bit);
    retry = !match && !armed && rd_word[TMO_BIT];
    fault = !match && armed;
  end

endmodule

// File: rtl/flash_word_track.sv
`timescale 1ns/1ps
module flash_word_track #(
  parameter int AW = 20,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] cur_addr,
  output logic          last
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= base_addr;
      remain   <= count;
    end else if (advance) begin
      cur_addr <= cur_addr + 1'b1;
      remain   <= remain - 1'b1;
    end
  end

  assign last = (remain == CW'(1));

endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int CW     = 20,
  parameter int WE_CYC = 3,
  parameter int RD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_count,
  input  logic [DW-1:0] dat_in,
  input  logic          dat_valid,
  output logic          dat_ready,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  output logic          done,
  output logic          error
);
  localparam logic [1:0] LAST_STEP = 2'd3;

  seq_state_t    state;
  logic [1:0]    step;
  logic [1:0]    nxt_step;
  logic [DW-1:0] data_q;
  logic          armed;
  logic          wr_go, rd_go;
  logic          cyc_done;
  logic [DW-1:0] rd_q;
  logic          match, retry, fault;
  logic          load, advance;
  logic [AW-1:0] cur_addr;
  logic          last;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          can_start;

  flash_strobe_gen #(.DW(DW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) u_strobe (
    .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go), .rd_in(bus_rdata),
    .we_n(bus_we_n), .oe_n(bus_oe_n), .cyc_done(cyc_done), .rd_q(rd_q)
  );

  flash_poll_eval #(.DW(DW)) u_eval (
    .rd_word(rd_q), .tgt_bit(data_q[POLL_BIT]), .armed(armed),
    .match(match), .retry(retry), .fault(fault)
  );

  flash_word_track #(.AW(AW), .CW(CW)) u_track (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .base_addr(start_addr), .count(word_count),
    .cur_addr(cur_addr), .last(last)
  );

  assign dat_ready = (state == S_FETCH);
  assign can_start = (state == S_IDLE) || (state == S_HALT);
  assign load      = can_start && start;
  assign advance   = (state == S_POLL) && cyc_done && match && !last;

  always_comb begin
    wr_go = 1'b0;
    rd_go = 1'b0;
    case (state)
      S_FETCH: wr_go = dat_valid;
      S_WRITE: if (cyc_done) begin
                 if (step == LAST_STEP) rd_go = 1'b1;
                 else                   wr_go = 1'b1;
               end
      S_POLL:  if (cyc_done && !match && !fault) rd_go = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    nxt_step = (state == S_FETCH) ? 2'd0 : step + 2'd1;
    case (nxt_step)
      2'd0:    begin wr_addr = AW'(UNLK_A0); wr_data = DW'(UNLK_D0); end
      2'd1:    begin wr_addr = AW'(UNLK_A1); wr_data = DW'(UNLK_D1); end
      2'd2:    begin wr_addr = AW'(UNLK_A0); wr_data = DW'(PGM_CMD); end
      default: begin wr_addr = cur_addr;     wr_data = data_q;       end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= 2'd0;
      data_q    <= '0;
      armed     <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (wr_go) begin
        bus_addr  <= wr_addr;
        bus_wdata <= wr_data;
        step      <= nxt_step;
      end
      case (state)
        S_IDLE, S_HALT: begin
          if (start) begin
            error <= 1'b0;
            if (word_count == '0) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (dat_valid) begin
            data_q <= dat_in;
            armed  <= 1'b0;
            state  <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (cyc_done && step == LAST_STEP) state <= S_POLL;
        end
        S_POLL: begin
          if (cyc_done) begin
            if (match) begin
              armed <= 1'b0;
              if (last) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else begin
                state <= S_FETCH;
              end
            end else if (fault) begin
              error <= 1'b1;
              state <= S_HALT;
            end else if (retry) begin
              armed <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

  // R5
  fetch_idle_chk: assert property (@(posedge clk) disable iff (rst)
    dat_ready |-> (bus_we_n && bus_oe_n));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    error |-> (bus_we_n && bus_oe_n && !dat_ready));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> error);

endmodule

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_prog_seq;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CW = 20;
  localparam int WE = 3;
  localparam int RD = 2;
  localparam int WORD_T_BASE = 4 * (WE + 1) + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [AW-1:0] start_addr;
  logic [CW-1:0] word_count;
  logic [DW-1:0] dat_in;
  logic          dat_valid;
  logic          dat_ready;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_we_n, bus_oe_n, done, error;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  flash_prog_seq #(.AW(AW), .DW(DW), .CW(CW), .WE_CYC(WE), .RD_CYC(RD)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .word_count(word_count), .dat_in(dat_in), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
    .done(done), .error(error)
  );

  // stream source
  logic          clr;
  logic [DW-1:0] base_data;
  int            feed_idx;
  always @(posedge clk) begin
    if (clr) feed_idx <= 0;
    else if (dat_valid && dat_ready) feed_idx <= feed_idx + 1;
  end
  assign dat_in = base_data + DW'(feed_idx);

  // flash model
  int            cfg_busy;
  bit            cfg_tmo;
  logic [AW-1:0] log_a [0:63];
  logic [DW-1:0] log_d [0:63];
  int wr_cnt, poll_cnt, busy_left, we_low, width_bad, overlap_bad;
  logic [DW-1:0] pend;
  logic prev_we = 1'b1, prev_oe = 1'b1;

  always_comb begin
    if (busy_left > 0) begin
      bus_rdata = pend ^ 16'h0080;
      bus_rdata[5] = cfg_tmo;
    end else begin
      bus_rdata = pend;
    end
  end

  always @(negedge clk) begin
    if (clr) begin
      wr_cnt = 0; poll_cnt = 0; busy_left = 0; we_low = 0;
      width_bad = 0; overlap_bad = 0;
    end else begin
      if (!bus_we_n && !bus_oe_n) overlap_bad++;
      if (!bus_we_n) we_low++;
      if (!prev_we && bus_we_n) begin
        if (we_low != WE) width_bad++;
        if (wr_cnt < 64) begin
          log_a[wr_cnt] = bus_addr;
          log_d[wr_cnt] = bus_wdata;
        end
        if (wr_cnt % 4 == 3) begin
          busy_left = cfg_busy;
          pend = bus_wdata;
        end
        wr_cnt++;
        we_low = 0;
      end
      if (!prev_oe && bus_oe_n) begin
        poll_cnt++;
        if (busy_left > 0) busy_left--;
      end
    end
    prev_we = bus_we_n;
    prev_oe = bus_oe_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clear_model();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // drives start, waits for done or error; returns edge index counted from start edge
  task automatic launch_wait(input logic [AW-1:0] a, input int n, input int inj_at,
                             output int cyc, output bit got_done, output bit got_err);
    start_addr = a; word_count = CW'(n); start = 1'b1;
    cyc = 0; got_done = 0; got_err = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (inj_at > 0 && cyc == inj_at) begin
        start_addr = a + 20'h00100; word_count = CW'(1); start = 1'b1;
      end
      if (done || error) begin
        got_done = done; got_err = error;
        start = 1'b0;
        return;
      end
      cyc++;
    end
    start = 1'b0;
  endtask

  task automatic check_log(input logic [AW-1:0] a, input int n, input logic [DW-1:0] b);
    chk(wr_cnt == 4 * n, "R2 write count", wr_cnt, 4 * n);
    for (int k = 0; k < n && k < 16; k++) begin
      chk(log_a[4*k] == 20'h555 && log_d[4*k] == 16'h00AA, "R2 unlock1", int'(log_d[4*k]), 'hAA);
      chk(log_a[4*k+1] == 20'h2AA && log_d[4*k+1] == 16'h0055, "R2 unlock2", int'(log_d[4*k+1]), 'h55);
      chk(log_a[4*k+2] == 20'h555 && log_d[4*k+2] == 16'h00A0, "R2 setup", int'(log_d[4*k+2]), 'hA0);
      chk(log_a[4*k+3] == a + AW'(k), "R5 target address", int'(log_a[4*k+3]), int'(a + AW'(k)));
      chk(log_d[4*k+3] == b + DW'(k), "R5 stream data", int'(log_d[4*k+3]), int'(b + DW'(k)));
    end
    chk(width_bad == 0, "R3 strobe width", width_bad, 0);
    chk(overlap_bad == 0, "R4 strobe overlap", overlap_bad, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; clr = 1'b0; dat_valid = 1'b1;
    start_addr = '0; word_count = '0; base_data = '0; cfg_busy = 0; cfg_tmo = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_we_n && bus_oe_n, "R1 strobes idle", {bus_we_n, bus_oe_n}, 3);
    chk(!done && !error && !dat_ready, "R1 flags low", {done, error, dat_ready}, 0);
  endtask

  task automatic t_job(input logic [AW-1:0] a, input int n, input logic [DW-1:0] b,
                       input int busy, input bit tmo, input string tag);
    int cyc, exp_cyc; bit gd, ge;
    clear_model();
    base_data = b; cfg_busy = busy; cfg_tmo = tmo;
    launch_wait(a, n, 0, cyc, gd, ge);
    exp_cyc = n * (WORD_T_BASE + (busy + 1) * (RD + 1));
    chk(gd && !ge, {"R6 done without error ", tag}, {gd, ge}, 2);
    chk(cyc == exp_cyc, {"R6 done edge ", tag}, cyc, exp_cyc);
    check_log(a, n, b);
    chk(poll_cnt == n * (busy + 1), {"R4 R8 read count ", tag}, poll_cnt, n * (busy + 1));
    @(negedge clk);
    chk(!done, {"R6 done one cycle ", tag}, done, 0);
  endtask

  task automatic t_tmo_error();
    int cyc, exp_cyc; bit gd, ge; int w0, p0;
    clear_model();
    base_data = 16'h5A81; cfg_busy = 100; cfg_tmo = 1;
    launch_wait(20'h0A000, 2, 0, cyc, gd, ge);
    exp_cyc = WORD_T_BASE + 2 * (RD + 1);
    chk(ge && !gd, "R7 error raised", {gd, ge}, 1);
    chk(cyc == exp_cyc, "R7 error edge", cyc, exp_cyc);
    chk(poll_cnt == 2, "R7 one extra read", poll_cnt, 2);
    w0 = wr_cnt; p0 = poll_cnt;
    repeat (30) begin
      @(negedge clk);
      if (!error || dat_ready || !bus_we_n || !bus_oe_n) break;
    end
    chk(error && !dat_ready, "R7 halted and sticky", {error, dat_ready}, 2);
    chk(wr_cnt == w0 && poll_cnt == p0, "R7 bus quiet", wr_cnt + poll_cnt, w0 + p0);
  endtask

  task automatic t_zero();
    int cyc; bit gd, ge;
    clear_model();
    launch_wait(20'h00040, 0, 0, cyc, gd, ge);
    chk(gd && cyc == 0, "R9 zero count done edge", cyc, 0);
    chk(wr_cnt == 0 && poll_cnt == 0, "R9 no bus activity", wr_cnt + poll_cnt, 0);
  endtask

  task automatic t_restart_ignored();
    int cyc, exp_cyc; bit gd, ge;
    clear_model();
    base_data = 16'h3300; cfg_busy = 1; cfg_tmo = 0;
    launch_wait(20'h02000, 2, 12, cyc, gd, ge);
    exp_cyc = 2 * (WORD_T_BASE + 2 * (RD + 1));
    chk(gd && cyc == exp_cyc, "R10 timing unchanged", cyc, exp_cyc);
    check_log(20'h02000, 2, 16'h3300);
  endtask

  initial begin
    t_reset();
    t_job(20'h01000, 1, 16'h1234, 2, 0, "single");
    t_job(20'h0FFFE, 3, 16'h00F0, 0, 0, "multi");
    t_job(20'h00300, 1, 16'h8000, 6, 0, "long poll R8");
    t_job(20'h00400, 1, 16'h7F7F, 1, 1, "tmo recovers R7");
    t_tmo_error();
    t_job(20'h00500, 1, 16'h00AA, 0, 0, "after error R7");
    chk(!error, "R7 start clears error", error, 0);
    t_zero();
    t_restart_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule